// File: doc/BRIEF.md
# Reloading Prescaler with Event Counter

This block divides a stream of tick enables by a programmable ratio and counts the completed periods. A down-counter steps toward zero on every tick. On the tick after it reaches zero, it reloads from a reload register, and an up-counting event counter advances by one on that same tick. The period between event-counter increments is therefore the reload value plus one tick. A reload value of zero leaves the down-counter resting at zero, so the event counter then advances on every tick.

The tick enable comes from elsewhere. It is normally a one-cycle pulse at 20 MHz derived from the system clock. The three 32-bit values can be read and written through a small register port. A write loads a value immediately, and counting resumes from the loaded value. The read data is a combinational view of the register selected by the address, as it stands after every tick clocked before the current cycle.

Top module: `reload_event_counter`

## Requirements
- R1: After reset the reload register, the down-counter and the event counter all read zero.
- R2: A tick while the down-counter is nonzero decrements it by exactly one and leaves the event counter unchanged.
- R3: A tick while the down-counter is zero loads it from the reload register and increments the event counter by one on that same tick.
- R4: In a cycle with neither a tick nor a write, the down-counter and the event counter hold their values.
- R5: With a reload value of zero, the down-counter stays at zero once it gets there, and the event counter increments on every tick.
- R6: Writing the reload register changes only the reload value. The down-counter continues from its current value.
- R7: A write to the down-counter or to the event counter loads the written value, and later ticks count on from it.
- R8: The event counter wraps from 0xFFFFFFFF to zero on an increment.
- R9: When a write and a tick fall in the same cycle, the written register takes the written value. The other counter still follows the tick rule.
- R10: Address encoding (addr_i): 0 selects the reload register, 1 the down-counter, 2 the event counter. Address 3 reads as zero, and writes to it change nothing.
- R11: rdata_o shows the addressed register in the same cycle as the address, including the effect of every tick clocked before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle prescale tick enable |
| wr_i | input | 1 | Write strobe for the register port |
| addr_i | input | 2 | Register select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register |

## Verification
The main function is driven through a full two-period countdown that starts above the reload value, with idle cycles mixed in among the ticks. This run separates decrement, reload-after-zero and hold, and it shows whether the increment lands on the reload tick rather than the zero tick. A zero reload value shows whether the block sticks at zero or wraps. Writes that coincide with ticks show that the written register wins while the other counter still follows the tick. A counter preset to all ones exposes the wrap.

// File: rtl/pscale_pkg.sv
package pscale_pkg;

    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_DOWN   = 2'd1,
        SEL_EVENTS = 2'd2,
        SEL_NONE   = 2'd3
    } sel_e;

endpackage

// File: rtl/pscale_down.sv
module pscale_down #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] reload_i,
    input  logic         tick_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] nxt_o,
    output logic         roll_o
);

    logic at_zero;

    assign at_zero = (cur_i == '0);
    assign roll_o  = tick_i && at_zero;

    always_comb begin
        nxt_o = cur_i;
        if (ld_i) begin
            nxt_o = ld_val_i;
        end else if (tick_i) begin
            nxt_o = at_zero ? reload_i : cur_i - W'(1);
        end
    end

endmodule

// File: rtl/pscale_events.sv
module pscale_events #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur_i,
    input  logic         inc_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] nxt_o
);

    always_comb begin
        nxt_o = cur_i;
        if (ld_i) begin
            nxt_o = ld_val_i;
        end else if (inc_i) begin
            nxt_o = cur_i + W'(1);
        end
    end

endmodule

// File: rtl/pscale_rdmux.sv
module pscale_rdmux #(
    parameter int W = 32
) (
    input  pscale_pkg::sel_e sel_i,
    input  logic [W-1:0]     reload_i,
    input  logic [W-1:0]     down_i,
    input  logic [W-1:0]     evt_i,
    output logic [W-1:0]     rdata_o
);

    always_comb begin
        unique case (sel_i)
            pscale_pkg::SEL_RELOAD: rdata_o = reload_i;
            pscale_pkg::SEL_DOWN:   rdata_o = down_i;
            pscale_pkg::SEL_EVENTS: rdata_o = evt_i;
            default:                rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/reload_event_counter.sv
module reload_event_counter #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         wr_i,
    input  logic [1:0]   addr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rdata_o
);

    import pscale_pkg::*;

    typedef struct packed {
        logic [W-1:0] reload;
        logic [W-1:0] down;
        logic [W-1:0] evt;
    } state_t;

    state_t state_d, state_q;

    sel_e         sel;
    logic         wr_reload, wr_down, wr_evt;
    logic [W-1:0] down_nxt, evt_nxt;
    logic         roll;

    // Exposed for the bound checker
    logic [W-1:0] reload_w, down_w, evt_w;

    assign sel       = sel_e'(addr_i);
    assign wr_reload = wr_i && (sel == SEL_RELOAD);
    assign wr_down   = wr_i && (sel == SEL_DOWN);
    assign wr_evt    = wr_i && (sel == SEL_EVENTS);

    pscale_down #(.W(W)) u_down (
        .cur_i    (state_q.down),
        .reload_i (state_q.reload),
        .tick_i   (tick_i),
        .ld_i     (wr_down),
        .ld_val_i (wdata_i),
        .nxt_o    (down_nxt),
        .roll_o   (roll)
    );

    pscale_events #(.W(W)) u_events (
        .cur_i    (state_q.evt),
        .inc_i    (roll),
        .ld_i     (wr_evt),
        .ld_val_i (wdata_i),
        .nxt_o    (evt_nxt)
    );

    always_comb begin
        state_d        = state_q;
        state_d.reload = wr_reload ? wdata_i : state_q.reload;
        state_d.down   = down_nxt;
        state_d.evt    = evt_nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    pscale_rdmux #(.W(W)) u_rdmux (
        .sel_i    (sel),
        .reload_i (state_q.reload),
        .down_i   (state_q.down),
        .evt_i    (state_q.evt),
        .rdata_o  (rdata_o)
    );

    assign reload_w = state_q.reload;
    assign down_w   = state_q.down;
    assign evt_w    = state_q.evt;

endmodule

// File: rtl/pscale_checker.sv
module pscale_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         wr,
    input logic [1:0]   addr,
    input logic [W-1:0] wdata,
    input logic [W-1:0] reload,
    input logic [W-1:0] down,
    input logic [W-1:0] evt
);

    logic wr_down, wr_evt;
    assign wr_down = wr && (addr == 2'd1);
    assign wr_evt  = wr && (addr == 2'd2);

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && down != '0 && !wr_down) |=> (down == $past(down) - W'(1))); // R2

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && down == '0 && !wr_down) |=> (down == $past(reload))); // R3

    AST_EVENT_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && down == '0 && !wr_evt) |=> (evt == $past(evt) + W'(1))); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr) |=> ($stable(down) && $stable(evt))); // R4

    AST_LOAD_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_down |=> (down == $past(wdata))); // R9

    AST_LOAD_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> (evt == $past(wdata))); // R7

endmodule

bind reload_event_counter pscale_checker #(.W(W)) u_pscale_checker (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .tick   (tick_i),
    .wr     (wr_i),
    .addr   (addr_i),
    .wdata  (wdata_i),
    .reload (reload_w),
    .down   (down_w),
    .evt    (evt_w)
);

// File: tb/test_reload_event_counter.sv
module test_reload_event_counter;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    reload_event_counter #(.W(W)) i_reload_event_counter (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .tick_i  (tick),
        .wr_i    (wr),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata)
    );

    // {tick, expected down, expected events}; start: reload 5, down 7, events 0
    localparam int NV = 16;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 8'd6, 8'd0}, {1'b1, 8'd5, 8'd0}, {1'b0, 8'd5, 8'd0}, {1'b1, 8'd4, 8'd0},
        {1'b1, 8'd3, 8'd0}, {1'b1, 8'd2, 8'd0}, {1'b1, 8'd1, 8'd0}, {1'b1, 8'd0, 8'd0},
        {1'b0, 8'd0, 8'd0}, {1'b1, 8'd5, 8'd1}, {1'b1, 8'd4, 8'd1}, {1'b1, 8'd3, 8'd1},
        {1'b1, 8'd2, 8'd1}, {1'b1, 8'd1, 8'd1}, {1'b1, 8'd0, 8'd1}, {1'b1, 8'd5, 8'd2}
    };

    task automatic cycle(input bit t, input bit w, input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        tick  = t;
        wr    = w;
        addr  = a;
        wdata = d;
        @(posedge clk);
        #1;
        tick = 1'b0;
        wr   = 1'b0;
    endtask

    task automatic check_reg(input logic [1:0] a, input logic [W-1:0] exp, input string req);
        addr = a;
        #1;
        checks++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%0d actual=0x%08h expected=0x%08h", req, a, rdata, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: all zero after reset
        check_reg(2'd0, 32'd0, "R1");
        check_reg(2'd1, 32'd0, "R1");
        check_reg(2'd2, 32'd0, "R1");
        rst_n = 1'b1;

        // Table walk: R2, R3, R4, R11
        cycle(1'b0, 1'b1, 2'd0, 32'd5);
        cycle(1'b0, 1'b1, 2'd1, 32'd7);
        for (int i = 0; i < NV; i++) begin
            cycle(VEC[i][16], 1'b0, 2'd0, '0);
            check_reg(2'd1, W'(VEC[i][15:8]), "R2_R3_R4_R11 down");
            check_reg(2'd2, W'(VEC[i][7:0]), "R2_R3_R4_R11 events");
        end

        // R5: zero reload sticks at zero, events on every tick
        cycle(1'b0, 1'b1, 2'd0, 32'd0);
        cycle(1'b0, 1'b1, 2'd1, 32'd2);
        cycle(1'b0, 1'b1, 2'd2, 32'd0);
        for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, 2'd0, '0);
        check_reg(2'd1, 32'd0, "R5");
        check_reg(2'd2, 32'd2, "R5");

        // R6: reload write leaves down-counter alone
        cycle(1'b0, 1'b1, 2'd1, 32'd3);
        cycle(1'b0, 1'b1, 2'd0, 32'd9);
        check_reg(2'd1, 32'd3, "R6");
        check_reg(2'd0, 32'd9, "R6");
        cycle(1'b1, 1'b0, 2'd0, '0);
        check_reg(2'd1, 32'd2, "R6");

        // R7: loads then counting continues
        cycle(1'b0, 1'b1, 2'd2, 32'd100);
        cycle(1'b0, 1'b1, 2'd1, 32'd1);
        cycle(1'b1, 1'b0, 2'd0, '0);
        check_reg(2'd1, 32'd0, "R7");
        check_reg(2'd2, 32'd100, "R7");
        cycle(1'b1, 1'b0, 2'd0, '0);
        check_reg(2'd1, 32'd9, "R7");
        check_reg(2'd2, 32'd101, "R7");

        // R8: wrap
        cycle(1'b0, 1'b1, 2'd2, 32'hFFFF_FFFF);
        cycle(1'b0, 1'b1, 2'd1, 32'd0);
        cycle(1'b1, 1'b0, 2'd0, '0);
        check_reg(2'd2, 32'd0, "R8");
        check_reg(2'd1, 32'd9, "R8");

        // R9: write coinciding with tick
        cycle(1'b0, 1'b1, 2'd1, 32'd0);
        cycle(1'b1, 1'b1, 2'd1, 32'd4);
        check_reg(2'd1, 32'd4, "R9 down written");
        check_reg(2'd2, 32'd1, "R9 events ticked");
        cycle(1'b1, 1'b1, 2'd2, 32'd50);
        check_reg(2'd2, 32'd50, "R9 events written");
        check_reg(2'd1, 32'd3, "R9 down ticked");

        // R10: unused address
        cycle(1'b0, 1'b1, 2'd3, 32'hDEAD_BEEF);
        check_reg(2'd3, 32'd0, "R10");
        check_reg(2'd0, 32'd9, "R10");
        check_reg(2'd1, 32'd3, "R10");
        check_reg(2'd2, 32'd50, "R10");

        // R1 again: reset mid-run clears everything
        rst_n = 1'b0;
        #1;
        check_reg(2'd0, 32'd0, "R1 rerun");
        check_reg(2'd1, 32'd0, "R1 rerun");
        check_reg(2'd2, 32'd0, "R1 rerun");
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule